// File: doc/BRIEF.md
# Fixed-Capacity Reshapeable Synchronous RAM

This block is a single-port synchronous memory whose capacity is always 2048 bits. At elaboration the integrator chooses one of four word shapes through the word width: 256 words of 8 bits, 512 of 4, 1024 of 2 or 2048 of 1. The address width follows from the shape. One address bus serves both reading and writing. A write-enable input, combined with reset and the storage mode, forms the internal write strobe.

Two independent stages can be kept or bypassed. The input stage registers address, write data and write enable on the input clock. The output stage registers the read word on its own output clock. With a stage bypassed, that path is combinational. A storage-mode parameter turns the block into a read-only table. In that mode the contents are computed at elaboration and writes are locked out.

The array and the output register have no reset. The active-low synchronous reset only suppresses writes and flushes a pending registered write enable. Whatever was stored, and whatever the output register holds, survives a reset.

Top module: `cfg_ram`

## Requirements
- R1: The word width DATA_W must be 8, 4, 2 or 1. The depth is 2048/DATA_W and the address width is log2 of the depth (8, 9, 10 or 11 bits). Any other width is rejected at elaboration by an assertion.
- R2: Write data is stored at the address when a write strobe occurs. A later read of that address returns the stored word, for every address of every shape.
- R3: With IN_REG=1, address, data and write enable are captured on a rising in_clk edge, and the capture takes effect one edge later. With IN_REG=0, the write happens on the in_clk edge at which wr_en is high. No write occurs while wr_en is low.
- R4: With OUT_REG=1, rd_data is the array word registered on out_clk. It holds its value while out_clk does not toggle.
- R5: With OUT_REG=0, rd_data follows the word at the current address stage without a clock. Writes become visible right after the writing edge.
- R6: If the output register samples on the same edge that writes its address, it captures the word as it was before that write (read-before-write).
- R7: While rst_n is low, no write takes effect, and a registered write enable is cleared. Neither the stored words nor rd_data are cleared by reset.
- R8: With ROM_MODE=1, word i holds the low DATA_W bits of (i*37 + 11) from time zero, and wr_en has no effect on the contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_clk | input | 1 | Clock for the input stage and the array write |
| out_clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset; blocks writes only |
| addr | input | ADDR_W | Word address for both read and write |
| wr_data | input | DATA_W | Word to be written |
| wr_en | input | 1 | Write request |
| rd_data | output | DATA_W | Word read at the current address |

## Verification
The bench goes after aliasing between shapes, because one shared stimulus bus drives all four shapes at once. A wrong address width or depth would read back a word written through a different alias. Pipeline timing is sampled edge by edge: a missing or extra input or output register shows up as the old word one cycle early or the new word one cycle late. The same-edge collision must return the old word, and a write-through design would return the new one. Other checks cover a stopped output clock, a reset held during a write request, and a write aimed at the read-only table. Each of these catches a design that lets reset clear the register or lets writes leak through.

// File: rtl/cfg_ram_pkg.sv
// Shared constants and helpers for the reshapeable RAM.
// Assumes: capacity is fixed; only word width is chosen by the user.
package cfg_ram_pkg;
    localparam int TOTAL_BITS = 2048;
    localparam int ROM_MULT   = 37;
    localparam int ROM_ADD    = 11;

    // True when the width gives one of the four supported shapes.
    function automatic bit shape_ok(input int w);
        return (w == 8) || (w == 4) || (w == 2) || (w == 1);
    endfunction

    // Table content for word idx in read-only mode (before truncation).
    function automatic int rom_value(input int idx);
        return idx * ROM_MULT + ROM_ADD;
    endfunction
endpackage

// File: rtl/cfg_ram_in_stage.sv
// Input stage: optionally registers address, data and write enable.
// Assumes: reset is synchronous, active low, and clears only the
// registered write enable; address and data have no reset.
module cfg_ram_in_stage #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              we_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              we_o
);
    generate
        if (REGISTERED) begin : g_reg
            logic [ADDR_W-1:0] addr_q;
            logic [DATA_W-1:0] data_q;
            logic              we_q;

            // Capture address and data every edge; no reset needed.
            always_ff @(posedge clk) begin
                addr_q <= addr_i;
                data_q <= data_i;
            end

            // Capture write enable, flushed while reset is held.
            always_ff @(posedge clk) begin
                if (!rst_n) we_q <= 1'b0;
                else        we_q <= we_i;
            end

            assign addr_o = addr_q;
            assign data_o = data_q;
            assign we_o   = we_q;
        end else begin : g_bypass
            assign addr_o = addr_i;
            assign data_o = data_i;
            assign we_o   = we_i;
        end
    endgenerate
endmodule

// File: rtl/cfg_ram_array.sv
// Storage array: DEPTH words of DATA_W bits, one write and one read
// on the same address. Read is combinational (old data until the edge).
// Assumes: DEPTH is a power of two, so every address is in range.
module cfg_ram_array #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 256,
    parameter bit ROM_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word
);
    import cfg_ram_pkg::*;

    logic [DATA_W-1:0] mem [DEPTH];

    generate
        if (ROM_MODE) begin : g_rom
            // Fill the table once with computed contents.
            initial begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i] = DATA_W'(rom_value(i));
                end
            end
        end else begin : g_ram
            // Store a word on each write strobe.
            always_ff @(posedge clk) begin
                if (wr_pulse) mem[addr] <= wr_data;
            end
        end
    endgenerate

    // Present the addressed word without a clock.
    assign rd_word = mem[addr];
endmodule

// File: rtl/cfg_ram_out_stage.sv
// Output stage: optionally registers the read word on its own clock.
// Assumes: no reset; the register keeps its value through a reset.
module cfg_ram_out_stage #(
    parameter int DATA_W     = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    generate
        if (REGISTERED) begin : g_reg
            logic [DATA_W-1:0] q;

            // Sample the array word on the output clock.
            always_ff @(posedge clk) begin
                q <= d_i;
            end

            assign q_o = q;
        end else begin : g_bypass
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/cfg_ram.sv
// Top: 2048-bit single-port RAM with a shape chosen by DATA_W.
// The input and output stages are independently registered or bypassed.
// Assumes: DATA_W in {8,4,2,1}; in_clk drives the input stage and the
// write, out_clk drives the output register; rst_n only blocks writes.
module cfg_ram #(
    parameter int DATA_W   = 8,
    parameter bit IN_REG   = 1'b1,
    parameter bit OUT_REG  = 1'b1,
    parameter bit ROM_MODE = 1'b0,
    localparam int DEPTH   = cfg_ram_pkg::TOTAL_BITS / DATA_W,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              in_clk,
    input  logic              out_clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              we_s;
    logic              wr_pulse;
    logic [DATA_W-1:0] arr_rd;

    cfg_ram_in_stage #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGISTERED(IN_REG)
    ) u_in (
        .clk(in_clk), .rst_n(rst_n),
        .addr_i(addr), .data_i(wr_data), .we_i(wr_en),
        .addr_o(addr_s), .data_o(data_s), .we_o(we_s)
    );

    // Form the write strobe: requested, out of reset, and writable.
    assign wr_pulse = we_s && rst_n && !ROM_MODE;

    cfg_ram_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .ROM_MODE(ROM_MODE)
    ) u_arr (
        .clk(in_clk), .wr_pulse(wr_pulse), .addr(addr_s),
        .wr_data(data_s), .rd_word(arr_rd)
    );

    cfg_ram_out_stage #(
        .DATA_W(DATA_W), .REGISTERED(OUT_REG)
    ) u_out (
        .clk(out_clk), .d_i(arr_rd), .q_o(rd_data)
    );
endmodule

// File: rtl/cfg_ram_chk.sv
// Checker bound to cfg_ram: shape legality, strobe origin, write
// landing, and read-only lockout.
module cfg_ram_chk #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 8,
    parameter bit IN_REG   = 1'b1,
    parameter bit ROM_MODE = 1'b0
) (
    input logic              in_clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_pulse,
    input logic [ADDR_W-1:0] addr_s,
    input logic [DATA_W-1:0] data_s,
    input logic [DATA_W-1:0] arr_rd
);
    import cfg_ram_pkg::*;

    // R1: only the four shapes elaborate cleanly
    initial begin
        assert_shape_legal_R1: assert (shape_ok(DATA_W))
            else $error("cfg_ram: unsupported word width %0d", DATA_W);
    end

    // R2: a strobed word is readable at its address on the next edge
    assert_write_lands_R2: assert property (@(posedge in_clk) disable iff (!rst_n)
        wr_pulse |=> (addr_s != $past(addr_s)) || (arr_rd == $past(data_s)));

    generate
        if (IN_REG) begin : g_reg_chk
            // R3: a registered strobe stems from wr_en one edge earlier
            assert_pulse_from_enable_R3: assert property (@(posedge in_clk) disable iff (!rst_n)
                wr_pulse |-> $past(wr_en));
        end else begin : g_byp_chk
            // R3: a bypassed strobe needs wr_en in the same cycle
            assert_pulse_from_enable_R3: assert property (@(posedge in_clk) disable iff (!rst_n)
                wr_pulse |-> wr_en);
        end
        if (ROM_MODE) begin : g_rom_chk
            // R8: the read-only table never sees a write strobe
            assert_rom_locked_R8: assert property (@(posedge in_clk) disable iff (!rst_n)
                !wr_pulse);
        end
    endgenerate
endmodule

bind cfg_ram cfg_ram_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IN_REG(IN_REG), .ROM_MODE(ROM_MODE)
) u_chk (
    .in_clk(in_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pulse(wr_pulse),
    .addr_s(addr_s), .data_s(data_s), .arr_rd(arr_rd)
);

// File: tb/sim_cfg_ram.sv
// Bench: five instances on one stimulus bus (four shapes plus a ROM),
// each checked against its own behavioural array model.
module sim_cfg_ram;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        oen = 1'b1;
    logic        oclk;
    logic        rst_n = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        we = 1'b0;

    logic [7:0] rd0;
    logic [3:0] rd1;
    logic [1:0] rd2;
    logic       rd3;
    logic [7:0] rd4;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] m0 [256];
    logic [7:0] m1 [512];
    logic [7:0] m2 [1024];
    logic [7:0] m3 [2048];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign oclk = clk & oen;

    cfg_ram #(.DATA_W(8), .IN_REG(1), .OUT_REG(1), .ROM_MODE(0)) u0 (
        .in_clk(clk), .out_clk(oclk), .rst_n(rst_n), .addr(addr[7:0]),
        .wr_data(wdata), .wr_en(we), .rd_data(rd0));
    cfg_ram #(.DATA_W(4), .IN_REG(0), .OUT_REG(1), .ROM_MODE(0)) u1 (
        .in_clk(clk), .out_clk(clk), .rst_n(rst_n), .addr(addr[8:0]),
        .wr_data(wdata[3:0]), .wr_en(we), .rd_data(rd1));
    cfg_ram #(.DATA_W(2), .IN_REG(1), .OUT_REG(0), .ROM_MODE(0)) u2 (
        .in_clk(clk), .out_clk(clk), .rst_n(rst_n), .addr(addr[9:0]),
        .wr_data(wdata[1:0]), .wr_en(we), .rd_data(rd2));
    cfg_ram #(.DATA_W(1), .IN_REG(0), .OUT_REG(0), .ROM_MODE(0)) u3 (
        .in_clk(clk), .out_clk(clk), .rst_n(rst_n), .addr(addr),
        .wr_data(wdata[0]), .wr_en(we), .rd_data(rd3));
    cfg_ram #(.DATA_W(8), .IN_REG(0), .OUT_REG(0), .ROM_MODE(1)) u4 (
        .in_clk(clk), .out_clk(clk), .rst_n(rst_n), .addr(addr[7:0]),
        .wr_data(wdata), .wr_en(we), .rd_data(rd4));

    // {address, data} pairs; several alias in the narrower-depth shapes
    localparam logic [18:0] VEC [12] = '{
        {11'd0,    8'h5A}, {11'd1,    8'hC3}, {11'd255,  8'h81},
        {11'd256,  8'h7E}, {11'd511,  8'h12}, {11'd512,  8'hED},
        {11'd1023, 8'h66}, {11'd1024, 8'h99}, {11'd1500, 8'h3B},
        {11'd2047, 8'hF0}, {11'd700,  8'h0F}, {11'd44,   8'hA4}};

    function automatic logic [7:0] rom_exp(input int a);
        return 8'((a % 256) * 37 + 11);
    endfunction

    function automatic logic [7:0] sweep_val(input int a);
        return 8'(a * 5 + 3) ^ 8'(a >> 8);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        m0[a % 256]  = d;
        m1[a % 512]  = d;
        m2[a % 1024] = d;
        m3[a]        = d;
    endtask

    // One write cycle on the shared bus (set up at the falling edge).
    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk);
        addr = 11'(a); wdata = d; we = 1'b1;
        model_write(a, d);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        we = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    // Settle a read on all instances and compare with the models.
    task automatic read_all(input int a, input string tag);
        @(negedge clk);
        addr = 11'(a); we = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk({tag, " R2 u0"}, rd0, m0[a % 256]);
        chk({tag, " R2 u1"}, {4'h0, rd1}, {4'h0, m1[a % 512][3:0]});
        chk({tag, " R2 u2"}, {6'h0, rd2}, {6'h0, m2[a % 1024][1:0]});
        chk({tag, " R2 u3"}, {7'h0, rd3}, {7'h0, m3[a][0]});
        chk({tag, " R8 u4"}, rd4, rom_exp(a));
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        // Reset state: the ROM holds its table from time zero (R8, R1 shape 256x8)
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("reset R8 rom[0]", rd4, rom_exp(0));
        addr = 11'd255;
        #1 chk("reset R8 rom[255]", rd4, rom_exp(255));
        rst_n = 1'b1;

        // Vector table: write every entry, then read every entry back
        foreach (VEC[i]) do_write(int'(VEC[i][18:8]), VEC[i][7:0]);
        idle(3);
        foreach (VEC[i]) read_all(int'(VEC[i][18:8]), "vec");

        // Full sweep over the deepest address range (all shapes, R1/R2)
        for (int a = 0; a < 2048; a++) do_write(a, sweep_val(a));
        idle(3);
        for (int a = 0; a < 2048; a++) read_all(a, "sweep");

        // Latency per stage variant (R3, R4, R5)
        do_write(5, 8'hA5);
        do_write(9, 8'h5A);
        idle(2);
        read_all(9, "lat-pre");
        @(negedge clk);
        addr = 11'd5;
        #1 chk("R5 u3 comb", {7'h0, rd3}, 8'h01);
        @(posedge clk);
        @(negedge clk);
        chk("R3 R4 u0 one edge", rd0, 8'h5A);
        chk("R4 u1 one edge", {4'h0, rd1}, 8'h05);
        chk("R3 R5 u2 one edge", {6'h0, rd2}, 8'h01);
        @(posedge clk);
        @(negedge clk);
        chk("R3 R4 u0 two edges", rd0, 8'hA5);

        // Same-edge collision on u0: old word captured (R6)
        @(negedge clk);
        we = 1'b1; wdata = 8'h3C;
        #1 chk("R5 u3 before edge", {7'h0, rd3}, 8'h01);
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
        model_write(5, 8'h3C);
        chk("R5 u3 after edge", {7'h0, rd3}, 8'h00);
        @(posedge clk);
        @(negedge clk);
        chk("R6 u0 old word", rd0, 8'hA5);
        @(posedge clk);
        @(negedge clk);
        chk("R6 u0 new word", rd0, 8'h3C);

        // Stopped output clock holds the register (R4)
        oen = 1'b0;
        addr = 11'd9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4 u0 hold", rd0, 8'h3C);
        oen = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R4 u0 resume", rd0, 8'h5A);

        // Reset blocks a write and clears nothing (R7)
        addr = 11'd5;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0; we = 1'b1; wdata = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 u3 no write in reset", {7'h0, rd3}, 8'h00);
        chk("R7 u0 output kept", rd0, 8'h3C);
        we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        read_all(5, "R7 after reset");

        // Write aimed at the ROM is ignored (R8)
        do_write(77, ~rom_exp(77));
        idle(2);
        read_all(77, "R8 rom write");

        finish_up();
    end
endmodule